// File: doc/BRIEF.md
# Game Card Word Transfer Controller

This block drives block reads from a game card, one 32-bit word at a time. Software first loads an eight-byte command, then an auxiliary control word, then a transfer control word. The auxiliary word carries a master enable and an interrupt enable. The transfer control word carries a start bit, a gap-select bit and a three-bit size code. Once a transfer starts, the block produces one word at a time. A word comes from a ROM request port, or from fixed logic for the all-ones dummy command and the chip-identity commands. A ready flag marks each word. The flag also serves as a DMA trigger. When the last word is taken, the block clears its busy and ready bits and can pulse a completion interrupt.

Two CPU ports share the block. A single ownership input picks which port may write the registers and read data. The other port is shut out completely: its writes do nothing and its reads return zero. The completion interrupt goes to whichever port owns the block when the transfer ends.

Top module: `card_xfer_ctrl`

## Requirements
- R1: After reset the control view and auxiliary view read 0, `wordReady` is 0 and `irqDone` is 0.
- R2: A write with select 0 stores the value ANDed with 32'hFF7F7FFF. Bits 23 and 15 of the stored copy are always 0. Bit 23 of `ctrlView` shows only `wordReady`.
- R3: A transfer starts only when the written control value has bit 31 set and auxiliary bit 15 is already set. Any other control write starts nothing, and no word becomes ready.
- R4: Control bits 26:24 give the transfer size. Code 0 means no data, code 7 means 4 bytes, and a code n from 1 to 6 means 256<<n bytes. Each word is 4 bytes.
- R5: A zero-size start ends at once. One cycle after the write, bit 31 is clear, and the interrupt pulses if it is enabled.
- R6: The first word becomes ready exactly G cycles after the start write. Each later word becomes ready exactly G cycles after the read that took the previous word. G is 5 when control bit 27 is 0 and 8 when it is 1.
- R7: A read by the owner while `wordReady` is 1 returns the word, clears `wordReady` and advances the position by 4. A read while no word is ready, including any read after the end, returns 0.
- R8: Taking the last word clears control bits 31 and 23. If auxiliary bit 14 is set, `irqDone` then pulses for one cycle on bit 0 when port 0 owns the block, or on bit 1 when port 1 owns it.
- R9: If command byte 0 (select 2, bits 7:0) is 8'h9F, every word is 32'hFFFFFFFF. If it is 8'h90, 8'hB8 or any 8'h1x, every word is `chipId`. No ROM request is made for these commands.
- R10: Any other command makes one `romReq` pulse per word. The pulse carries the word's byte offset on `romAddr`, and the command buffer is on `romCmd` (select 3 data in bits 63:32). The word delivered is the data returned with `romValid`.
- R11: With `cardOwner` 0 only port 0 is served, and with 1 only port 1. Writes from the other port change nothing, and its reads return 0 without consuming a word.
- R12: A start write during a busy transfer restarts it. The position returns to 0, and the first word comes again after a full gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cardOwner | input | 1 | Ownership bit of the memory control word; 0 selects port 0 |
| cpu0WrEn | input | 1 | Port 0 register write strobe |
| cpu0WrSel | input | 2 | Port 0 register select: 0 control, 1 auxiliary, 2 command bytes 0-3, 3 command bytes 4-7 |
| cpu0WrData | input | 32 | Port 0 write data |
| cpu0RdEn | input | 1 | Port 0 data-word read strobe |
| cpu0RdData | output | 32 | Port 0 read data |
| cpu1WrEn | input | 1 | Port 1 register write strobe |
| cpu1WrSel | input | 2 | Port 1 register select |
| cpu1WrData | input | 32 | Port 1 write data |
| cpu1RdEn | input | 1 | Port 1 data-word read strobe |
| cpu1RdData | output | 32 | Port 1 read data |
| chipId | input | 32 | Identity word for the ID commands |
| romReq | output | 1 | One-cycle ROM word request |
| romAddr | output | LEN_W | Byte offset of the requested word |
| romCmd | output | 64 | Command buffer presented with the request |
| romData | input | 32 | ROM word |
| romValid | input | 1 | ROM word valid |
| ctrlView | output | 32 | Control register as software reads it |
| auxView | output | 16 | Auxiliary control register |
| wordReady | output | 1 | A data word is ready (DMA trigger) |
| irqDone | output | 2 | Completion interrupt pulse, one bit per port |

## Verification
The bench measures the gap before every word in both speed settings. A design with an off-by-one counter, or one that keeps the old gap setting through a start, would show a 4-, 6- or 9-cycle spacing. It covers the smallest one-word size, the zero size and the largest 16 KiB size. A wrong size decode or a final-word compare that misses would give the wrong word count, a missing interrupt, or a transfer that never ends. It also covers a restart in mid-transfer, a non-owner read landing on a ready word, and a start written while the enable is clear. Errors there would show as data resuming from the old offset, a word stolen by the wrong port, or a transfer begun that software never enabled.

// File: rtl/cx_pkg.sv
package cx_pkg;

  // Word source chosen from the first command byte
  typedef enum logic [1:0] {
    SRC_ROM  = 2'd0,
    SRC_ONES = 2'd1,
    SRC_ID   = 2'd2
  } srcKind_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic start;    // accepted start with nonzero length
    logic fetch;    // obtain the next word
    logic present;  // gap elapsed: expose fetched word
    logic consume;  // owner took the ready word
    logic finish;   // transfer ends this cycle
  } xferStrb_t;

  localparam logic [31:0] CTRL_WR_MASK = 32'hFF7F7FFF;

  function automatic srcKind_t classifyCmd(input logic [7:0] op);
    if (op == 8'h9F) return SRC_ONES;
    if (op == 8'h90 || op == 8'hB8 || op[7:4] == 4'h1) return SRC_ID;
    return SRC_ROM;
  endfunction

endpackage

// File: rtl/cx_datapath.sv
module cx_datapath
  import cx_pkg::*;
#(
  parameter int LEN_W = 15,
  parameter int PORTS = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  owner,
  input  logic [PORTS-1:0]      wrEnV,
  input  logic [PORTS-1:0][1:0] wrSelV,
  input  logic [PORTS-1:0][31:0] wrDataV,
  input  logic [PORTS-1:0]      rdEnV,
  output logic [PORTS-1:0][31:0] rdDataV,
  input  xferStrb_t             strb,
  input  logic                  wordReady,
  input  logic [31:0]           chipId,
  input  logic [31:0]           romData,
  input  logic                  romValid,
  output logic                  startReq,
  output logic                  lenZero,
  output logic                  readReq,
  output logic                  lastWord,
  output logic                  slowGap,
  output logic                  irqEn,
  output logic                  romReq,
  output logic [LEN_W-1:0]      romAddr,
  output logic [63:0]           romCmd,
  output logic [31:0]           ctrlView,
  output logic [15:0]           auxView
);

  localparam logic [LEN_W-1:0] WORD_BYTES = LEN_W'(4);

  function automatic logic [LEN_W-1:0] sizeBytes(input logic [2:0] code);
    case (code)
      3'd0:    return '0;
      3'd7:    return WORD_BYTES;
      default: return LEN_W'(256) << code;
    endcase
  endfunction

  logic [31:0]      ctrlReg;
  logic [15:0]      auxReg;
  logic [63:0]      cmdBuf;
  logic [LEN_W-1:0] posReg, lenReg, nextAddr;
  srcKind_t         srcKind, nextKind;
  logic [31:0]      fetchWord, outWord;

  logic        wrEn;
  logic [1:0]  wrSel;
  logic [31:0] wrData;
  logic        ctrlWr;

  assign wrEn   = wrEnV[owner];
  assign wrSel  = wrSelV[owner];
  assign wrData = wrDataV[owner];
  assign readReq = rdEnV[owner];

  assign ctrlWr   = wrEn && (wrSel == 2'd0);
  assign startReq = ctrlWr && auxReg[15] && wrData[31];
  assign lenZero  = (sizeBytes(wrData[26:24]) == '0);
  assign slowGap  = startReq ? wrData[27] : ctrlReg[27];
  assign irqEn    = auxReg[14];
  assign lastWord = (posReg + WORD_BYTES) == lenReg;
  assign nextKind = strb.start ? classifyCmd(cmdBuf[7:0]) : srcKind;
  assign nextAddr = strb.start ? '0 : posReg + WORD_BYTES;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      auxReg    <= '0;
      cmdBuf    <= '0;
      posReg    <= '0;
      lenReg    <= '0;
      srcKind   <= SRC_ROM;
      fetchWord <= '0;
      outWord   <= '0;
      romReq    <= 1'b0;
      romAddr   <= '0;
    end else begin
      romReq <= 1'b0;
      if (wrEn) begin
        case (wrSel)
          2'd0: ctrlReg        <= wrData & CTRL_WR_MASK;
          2'd1: auxReg         <= wrData[15:0];
          2'd2: cmdBuf[31:0]   <= wrData;
          default: cmdBuf[63:32] <= wrData;
        endcase
      end
      if (strb.finish) ctrlReg[31] <= 1'b0;
      if (strb.start) begin
        posReg  <= '0;
        lenReg  <= sizeBytes(wrData[26:24]);
        srcKind <= nextKind;
      end else if (strb.consume) begin
        posReg <= posReg + WORD_BYTES;
      end
      if (romValid) fetchWord <= romData;
      if (strb.fetch) begin
        case (nextKind)
          SRC_ONES: fetchWord <= '1;
          SRC_ID:   fetchWord <= chipId;
          default: begin
            romReq  <= 1'b1;
            romAddr <= nextAddr;
          end
        endcase
      end
      if (strb.present) outWord <= fetchWord;
    end
  end

  // Per-port read mux: only the owner sees a ready word
  for (genvar p = 0; p < PORTS; p++) begin : g_rd
    assign rdDataV[p] = (owner == p[0] && rdEnV[p] && wordReady) ? outWord : '0;
  end

  assign romCmd   = cmdBuf;
  assign ctrlView = ctrlReg | {8'h00, wordReady, 23'h0};
  assign auxView  = auxReg;

endmodule

// File: rtl/cx_control.sv
module cx_control
  import cx_pkg::*;
#(
  parameter int GAP_FAST = 5,
  parameter int GAP_SLOW = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      owner,
  input  logic      startReq,
  input  logic      lenZero,
  input  logic      readReq,
  input  logic      lastWord,
  input  logic      slowGap,
  input  logic      irqEn,
  output xferStrb_t strb,
  output logic      wordReady,
  output logic [1:0] irqDone
);

  localparam int GAP_MAX = (GAP_SLOW > GAP_FAST) ? GAP_SLOW : GAP_FAST;
  localparam int CNT_W   = $clog2(GAP_MAX + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_READY} xferState_t;

  xferState_t  state;
  logic [CNT_W-1:0] gapCnt, gapLoad;

  assign gapLoad = slowGap ? CNT_W'(GAP_SLOW) : CNT_W'(GAP_FAST);

  always_comb begin
    strb         = '0;
    strb.start   = startReq && !lenZero;
    strb.consume = (state == ST_READY) && readReq && !startReq;
    strb.present = (state == ST_WAIT) && (gapCnt == CNT_W'(1)) && !startReq;
    strb.finish  = (startReq && lenZero) || (strb.consume && lastWord);
    strb.fetch   = strb.start || (strb.consume && !lastWord);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      gapCnt  <= '0;
      irqDone <= 2'b00;
    end else begin
      if (startReq) begin
        state  <= lenZero ? ST_IDLE : ST_WAIT;
        gapCnt <= gapLoad;
      end else begin
        case (state)
          ST_WAIT: begin
            if (gapCnt == CNT_W'(1)) state <= ST_READY;
            else gapCnt <= gapCnt - CNT_W'(1);
          end
          ST_READY: begin
            if (strb.consume) begin
              state  <= lastWord ? ST_IDLE : ST_WAIT;
              gapCnt <= gapLoad;
            end
          end
          default: ;
        endcase
      end
      irqDone <= (strb.finish && irqEn) ? (owner ? 2'b10 : 2'b01) : 2'b00;
    end
  end

  assign wordReady = (state == ST_READY);

endmodule

// File: rtl/card_xfer_ctrl.sv
module card_xfer_ctrl
  import cx_pkg::*;
#(
  parameter int LEN_W    = 15,
  parameter int GAP_FAST = 5,
  parameter int GAP_SLOW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cardOwner,
  input  logic             cpu0WrEn,
  input  logic [1:0]       cpu0WrSel,
  input  logic [31:0]      cpu0WrData,
  input  logic             cpu0RdEn,
  output logic [31:0]      cpu0RdData,
  input  logic             cpu1WrEn,
  input  logic [1:0]       cpu1WrSel,
  input  logic [31:0]      cpu1WrData,
  input  logic             cpu1RdEn,
  output logic [31:0]      cpu1RdData,
  input  logic [31:0]      chipId,
  output logic             romReq,
  output logic [LEN_W-1:0] romAddr,
  output logic [63:0]      romCmd,
  input  logic [31:0]      romData,
  input  logic             romValid,
  output logic [31:0]      ctrlView,
  output logic [15:0]      auxView,
  output logic             wordReady,
  output logic [1:0]       irqDone
);

  xferStrb_t strb;
  logic startReq, lenZero, readReq, lastWord, slowGap, irqEn;
  logic [1:0][31:0] rdDataV;

  cx_datapath #(.LEN_W(LEN_W), .PORTS(2)) u_dp (
    .clk(clk), .rstN(rstN), .owner(cardOwner),
    .wrEnV({cpu1WrEn, cpu0WrEn}),
    .wrSelV({cpu1WrSel, cpu0WrSel}),
    .wrDataV({cpu1WrData, cpu0WrData}),
    .rdEnV({cpu1RdEn, cpu0RdEn}),
    .rdDataV(rdDataV),
    .strb(strb), .wordReady(wordReady),
    .chipId(chipId), .romData(romData), .romValid(romValid),
    .startReq(startReq), .lenZero(lenZero), .readReq(readReq),
    .lastWord(lastWord), .slowGap(slowGap), .irqEn(irqEn),
    .romReq(romReq), .romAddr(romAddr), .romCmd(romCmd),
    .ctrlView(ctrlView), .auxView(auxView)
  );

  cx_control #(.GAP_FAST(GAP_FAST), .GAP_SLOW(GAP_SLOW)) u_ctl (
    .clk(clk), .rstN(rstN), .owner(cardOwner),
    .startReq(startReq), .lenZero(lenZero), .readReq(readReq),
    .lastWord(lastWord), .slowGap(slowGap), .irqEn(irqEn),
    .strb(strb), .wordReady(wordReady), .irqDone(irqDone)
  );

  assign cpu0RdData = rdDataV[0];
  assign cpu1RdData = rdDataV[1];

endmodule

// File: rtl/cx_checker.sv
module cx_checker #(
  parameter int LEN_W = 15
) (
  input logic             clk,
  input logic             rstN,
  input logic             cardOwner,
  input logic             cpu0WrEn,
  input logic             cpu1WrEn,
  input logic             cpu0RdEn,
  input logic             cpu1RdEn,
  input logic [31:0]      cpu0RdData,
  input logic [31:0]      cpu1RdData,
  input logic             wordReady,
  input logic [1:0]       irqDone,
  input logic             romReq,
  input logic [LEN_W-1:0] romAddr
);

  logic ownerRd, ownerWr;
  assign ownerRd = cardOwner ? cpu1RdEn : cpu0RdEn;
  assign ownerWr = cardOwner ? cpu1WrEn : cpu0WrEn;

  // R8: completion interrupt is a single-cycle pulse on at most one port
  a_r8_irq_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqDone));
  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    (|irqDone) |=> (irqDone == 2'b00));

  // R7: an owner read of a ready word drops the ready flag
  a_r7_read_drops_ready: assert property (@(posedge clk) disable iff (!rstN)
    (wordReady && ownerRd && !ownerWr) |=> !wordReady);

  // R6: no word becomes ready sooner than the shortest gap
  a_r6_gap_floor: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wordReady) |-> !$past(wordReady, 4));

  // R11: the port without ownership reads zero
  a_r11_port0_silent: assert property (@(posedge clk) disable iff (!rstN)
    cardOwner |-> (cpu0RdData == 32'h0));
  a_r11_port1_silent: assert property (@(posedge clk) disable iff (!rstN)
    !cardOwner |-> (cpu1RdData == 32'h0));

  // R10: ROM requests carry word-aligned byte offsets
  a_r10_rom_aligned: assert property (@(posedge clk) disable iff (!rstN)
    romReq |-> (romAddr[1:0] == 2'b00));

endmodule

bind card_xfer_ctrl cx_checker #(.LEN_W(LEN_W)) u_cx_checker (
  .clk(clk), .rstN(rstN), .cardOwner(cardOwner),
  .cpu0WrEn(cpu0WrEn), .cpu1WrEn(cpu1WrEn),
  .cpu0RdEn(cpu0RdEn), .cpu1RdEn(cpu1RdEn),
  .cpu0RdData(cpu0RdData), .cpu1RdData(cpu1RdData),
  .wordReady(wordReady), .irqDone(irqDone),
  .romReq(romReq), .romAddr(romAddr)
);

// File: tb/tb_card_xfer_ctrl.sv
module tb_card_xfer_ctrl;

  localparam int LEN_W = 15;
  localparam logic [31:0] CHIP_ID = 32'h5A3C0177;
  localparam logic [31:0] CMD_HI  = 32'hA1B2C3D4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, cardOwner;
  logic c0WrEn, c0RdEn, c1WrEn, c1RdEn;
  logic [1:0] c0WrSel, c1WrSel;
  logic [31:0] c0WrData, c1WrData, c0RdData, c1RdData;
  logic romReq, romValid, wordReady;
  logic [LEN_W-1:0] romAddr;
  logic [63:0] romCmd;
  logic [31:0] romData, ctrlView;
  logic [15:0] auxView;
  logic [1:0] irqDone;

  card_xfer_ctrl #(.LEN_W(LEN_W)) dut (
    .clk(clk), .rstN(rstN), .cardOwner(cardOwner),
    .cpu0WrEn(c0WrEn), .cpu0WrSel(c0WrSel), .cpu0WrData(c0WrData),
    .cpu0RdEn(c0RdEn), .cpu0RdData(c0RdData),
    .cpu1WrEn(c1WrEn), .cpu1WrSel(c1WrSel), .cpu1WrData(c1WrData),
    .cpu1RdEn(c1RdEn), .cpu1RdData(c1RdData),
    .chipId(CHIP_ID), .romReq(romReq), .romAddr(romAddr), .romCmd(romCmd),
    .romData(romData), .romValid(romValid),
    .ctrlView(ctrlView), .auxView(auxView), .wordReady(wordReady),
    .irqDone(irqDone)
  );

  int checks = 0;
  int errors = 0;
  int romReqSeen = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // ROM model: answers each request one cycle later with base + offset
  initial begin
    romValid = 1'b0;
    romData  = '0;
    forever begin
      @(negedge clk);
      romValid = 1'b0;
      if (romReq) begin
        romReqSeen++;
        romData  = 32'hC0DE0000 + 32'(romAddr);
        romValid = 1'b1;
      end
    end
  end

  task automatic wr(input int p, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    if (p == 0) begin c0WrEn = 1'b1; c0WrSel = sel; c0WrData = d; end
    else        begin c1WrEn = 1'b1; c1WrSel = sel; c1WrData = d; end
    @(negedge clk);
    c0WrEn = 1'b0;
    c1WrEn = 1'b0;
  endtask

  task automatic rd(input int p, output logic [31:0] v);
    @(negedge clk);
    if (p == 0) c0RdEn = 1'b1; else c1RdEn = 1'b1;
    #1 v = (p == 0) ? c0RdData : c1RdData;
    @(negedge clk);
    c0RdEn = 1'b0;
    c1RdEn = 1'b0;
  endtask

  task automatic waitReady(output int cnt);
    cnt = 0;
    while (!wordReady && cnt < 20) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  // kind: 0 ROM data, 1 all ones, 2 chip identity
  typedef struct packed {
    logic [2:0]  sz;
    logic        slow;
    logic [7:0]  cmd;
    logic [1:0]  kind;
    logic [12:0] words;
  } vec_t;

  localparam int N_VEC = 6;
  localparam vec_t VECS [N_VEC] = '{
    '{3'd7, 1'b0, 8'h9F, 2'd1, 13'd1},
    '{3'd1, 1'b0, 8'hB7, 2'd0, 13'd128},
    '{3'd0, 1'b1, 8'h90, 2'd2, 13'd0},
    '{3'd2, 1'b1, 8'hB8, 2'd2, 13'd256},
    '{3'd7, 1'b1, 8'h1A, 2'd2, 13'd1},
    '{3'd6, 1'b0, 8'h00, 2'd0, 13'd4096}
  };

  function automatic logic [31:0] expWord(input vec_t v, input int i);
    case (v.kind)
      2'd1:    return 32'hFFFFFFFF;
      2'd2:    return CHIP_ID;
      default: return 32'hC0DE0000 + 32'(i * 4);
    endcase
  endfunction

  task automatic runVec(input vec_t v);
    int gap, cnt, badGap, badWord;
    logic [31:0] got, firstAct, firstExp;
    gap = v.slow ? 8 : 5;
    badGap = 0; badWord = 0; firstAct = '0; firstExp = '0;
    romReqSeen = 0;
    wr(0, 2'd2, {24'h123456, v.cmd});
    wr(0, 2'd3, CMD_HI);
    wr(0, 2'd1, 32'h0000C000);
    wr(0, 2'd0, 32'h80000000 | (32'(v.slow) << 27) | (32'(v.sz) << 24));
    if (v.words == 0) begin
      check(ctrlView[31] == 1'b0, "R5 zero size ends at once", ctrlView, 32'h0);
      check(irqDone == 2'b01, "R5 zero size interrupt", 32'(irqDone), 32'h1);
      repeat (10) @(negedge clk);
      check(!wordReady, "R4 code 0 gives no data", 32'(wordReady), 32'h0);
    end else begin
      for (int i = 0; i < int'(v.words); i++) begin
        waitReady(cnt);
        if (cnt != gap) badGap++;
        rd(0, got);
        if (got != expWord(v, i)) begin
          if (badWord == 0) begin firstAct = got; firstExp = expWord(v, i); end
          badWord++;
        end
        if (i == int'(v.words) - 1)
          check(irqDone == 2'b01, "R8 interrupt to owner at end", 32'(irqDone), 32'h1);
      end
      check(badWord == 0, "R4 R9 R10 word values and count", firstAct, firstExp);
      check(badGap == 0, "R6 word gap", 32'(badGap), 32'h0);
      check(ctrlView[31] == 1'b0 && !wordReady, "R8 end clears busy and ready",
            ctrlView, 32'h0);
      rd(0, got);
      check(got == 32'h0, "R7 read past end", got, 32'h0);
    end
    check(romReqSeen == ((v.kind == 2'd0) ? int'(v.words) : 0),
          "R9 R10 ROM request count", 32'(romReqSeen),
          (v.kind == 2'd0) ? 32'(v.words) : 32'h0);
    if (v.kind == 2'd0)
      check(romCmd == {CMD_HI, 24'h123456, v.cmd}, "R10 command on ROM port",
            romCmd[31:0], {24'h123456, v.cmd});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finishRun();
    end
  end

  initial begin
    logic [31:0] got;
    int cnt;
    rstN = 1'b0; cardOwner = 1'b0;
    c0WrEn = 0; c0WrSel = 0; c0WrData = 0; c0RdEn = 0;
    c1WrEn = 0; c1WrSel = 0; c1WrData = 0; c1RdEn = 0;
    repeat (3) @(negedge clk);
    check(ctrlView == 32'h0 && auxView == 16'h0, "R1 reset registers", ctrlView, 32'h0);
    check(!wordReady && irqDone == 2'b00, "R1 reset flags",
          {30'h0, irqDone} | 32'(wordReady), 32'h0);
    rstN = 1'b1;

    // Table walk
    for (int k = 0; k < N_VEC; k++) runVec(VECS[k]);

    // R2 and R3: enable clear, start bit set
    wr(0, 2'd1, 32'h0);
    wr(0, 2'd0, 32'hFFFFFFFF);
    check(ctrlView == 32'hFF7F7FFF, "R2 write mask", ctrlView, 32'hFF7F7FFF);
    repeat (10) @(negedge clk);
    check(!wordReady, "R3 no start without enable", 32'(wordReady), 32'h0);
    // R3: enable set, start bit clear
    wr(0, 2'd1, 32'h8000);
    wr(0, 2'd2, 32'h9F);
    wr(0, 2'd0, 32'h07000000);
    repeat (10) @(negedge clk);
    check(!wordReady, "R3 no start without bit 31", 32'(wordReady), 32'h0);

    // R8: interrupt disabled
    wr(0, 2'd0, 32'h87000000);
    waitReady(cnt);
    rd(0, got);
    check(got == 32'hFFFFFFFF, "R9 dummy fill word", got, 32'hFFFFFFFF);
    check(irqDone == 2'b00, "R8 no interrupt when disabled", 32'(irqDone), 32'h0);

    // R12: restart mid-transfer
    wr(0, 2'd1, 32'hC000);
    wr(0, 2'd2, 32'hB7);
    wr(0, 2'd0, 32'h81000000);
    for (int i = 0; i < 3; i++) begin waitReady(cnt); rd(0, got); end
    wr(0, 2'd0, 32'h81000000);
    waitReady(cnt);
    check(cnt == 5, "R12 full gap after restart", 32'(cnt), 32'd5);
    rd(0, got);
    check(got == 32'hC0DE0000, "R12 restart from offset 0", got, 32'hC0DE0000);

    // R11: ownership moves to port 1
    cardOwner = 1'b1;
    wr(0, 2'd1, 32'h0);
    check(auxView == 16'hC000, "R11 non-owner write ignored", 32'(auxView), 32'hC000);
    wr(1, 2'd2, 32'h9F);
    wr(1, 2'd0, 32'h87000000);
    waitReady(cnt);
    rd(0, got);
    check(got == 32'h0 && wordReady, "R11 non-owner read is zero and consumes nothing",
          got, 32'h0);
    rd(1, got);
    check(got == 32'hFFFFFFFF, "R11 owner read", got, 32'hFFFFFFFF);
    check(irqDone == 2'b10, "R8 interrupt to port 1", 32'(irqDone), 32'h2);

    finishRun();
  end

endmodule